// File: doc/BRIEF.md
# Current-Sense Short Detector

This block watches for a shorted current-sense resistor in a peak-current-mode converter. If the resistor is shorted, the sense voltage stays near zero throughout the on-time. The current loop then never terminates the pulse and the switch is overstressed. On every gate turn-on the block waits a fixed on-time and then compares one sampled sense code against a threshold. The sense code comes from an external converter. The threshold rises with the rectified line voltage, because a healthy sense waveform is steeper at high line. Cycles whose on-time ends before the sample point are skipped. A run of low samples on consecutive sampled cycles produces a one-cycle auto-restart shutdown request to the supervisor. The supervisor re-arms the detector with a clear strobe once the restart has happened.

A leading-edge blanking window is produced from the same on-time counter. It masks the raw output of the cycle-by-cycle current-limit comparator just after turn-on, so that the turn-on spike cannot end the pulse. The computed threshold is also driven out, so that an external comparator can use it as its reference.

With default parameters, the block assumes a 100 MHz clock. Blanking lasts 28 clocks (280 ns). The sample point is 455 clocks (4.55 µs), which lies inside the 85 % maximum on-time at 65 kHz. Eleven consecutive low samples are required.

Top module: `cs_short_det`

## Requirements
- R1: `thresh_mv` (8-bit, 1 mV per LSB) follows `line_code` (10-bit, 1 V DC per LSB) one clock later. It is 50 at or below 122, 100 at or above 366, and 50 + floor((code-122)*50/244) in between. It is 50 during reset.
- R2: A sample is taken at the clock edge where the gate has been high for `SAMPLE_CYC`+1 consecutive edges. The sample counts as low only when `sense_mv` (8-bit, 1 mV per LSB) is strictly below `thresh_mv`. A value equal to the threshold passes.
- R3: `fault_req` is asserted the clock after the 11th consecutive low sample. No pulse occurs after 10.
- R4: A single passing sample clears the run of low samples to zero.
- R5: A gate pulse that ends before the sample point neither counts as low nor clears the run.
- R6: `fault_req` is high for exactly one clock per detection.
- R7: After a pulse, further low runs produce no pulse until `clr_req` is seen. `clr_req` also zeroes the run.
- R8: `leb_blank` is high from gate rise for 28 edges (`LEB_CYC`). While it is high, `ilim_trip` stays low whatever `ilim_raw` does.
- R9: `ilim_trip` follows `ilim_raw` only while the gate is high and blanking has ended. It is low whenever the gate is low.
- R10: During and right after reset, `fault_req`, `leb_blank` and `ilim_trip` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_in | input | 1 | Gate-drive command, high during on-time |
| sense_mv | input | 8 | Sampled sense voltage, 1 mV per LSB |
| line_code | input | 10 | Rectified line voltage, 1 V per LSB |
| ilim_raw | input | 1 | Raw current-limit comparator output |
| clr_req | input | 1 | Re-arm strobe from the supervisor |
| fault_req | output | 1 | One-clock shutdown request |
| leb_blank | output | 1 | Blanking window active |
| ilim_trip | output | 1 | Blanked current-limit trip |
| thresh_mv | output | 8 | Current detection threshold, 1 mV per LSB |

## Verification
Some rules can be judged from one or two cycles of port activity, and the checker enforces those on every clock. They are: the single-cycle width of the request, the absence of a second request before a clear, a request only right after gate-high time, trips never overlapping the blanking window, and the threshold staying within its two end points. Other behaviour depends on the sequence of earlier cycles, so only the bench scenarios show it. That covers the exact count of eleven, a reset by one passing sample, short pulses being skipped without disturbing the run, the strict comparison at equality, and the interpolated threshold values.

// File: rtl/cs_short_pkg.sv
package cs_short_pkg;

    localparam int LINE_W      = 10;
    localparam int SENSE_W     = 8;
    localparam int THR_W       = 8;

    // line-voltage end points (V DC) and threshold end points (mV)
    localparam int LINE_LO_V   = 122;
    localparam int LINE_HI_V   = 366;
    localparam int THR_LO_MV   = 50;
    localparam int THR_HI_MV   = 100;

    // switching frame in clock cycles at 100 MHz
    localparam int SW_PERIOD_CYC = 1538;
    localparam int DMAX_PCT      = 85;
    localparam int MAX_ON_CYC    = SW_PERIOD_CYC * DMAX_PCT / 100;

    typedef struct packed {
        logic strobe;
        logic blank;
    } on_info_t;

    typedef enum logic [0:0] {
        ARM_READY = 1'b0,
        ARM_SPENT = 1'b1
    } arm_state_t;

    function automatic logic [THR_W-1:0] thr_from_line(input logic [LINE_W-1:0] code);
        int vi;
        int num;
        vi = int'(code);
        if (vi <= LINE_LO_V) return THR_W'(THR_LO_MV);
        if (vi >= LINE_HI_V) return THR_W'(THR_HI_MV);
        num = (vi - LINE_LO_V) * (THR_HI_MV - THR_LO_MV);
        return THR_W'(THR_LO_MV + num / (LINE_HI_V - LINE_LO_V));
    endfunction

endpackage

// File: rtl/cs_on_timer.sv
module cs_on_timer
    import cs_short_pkg::*;
#(
    parameter int LEB_CYC    = 28,
    parameter int SAMPLE_CYC = 455
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     gate_in,
    output on_info_t info
);
    localparam int CNT_MAX = SAMPLE_CYC + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);

    generate
        if (LEB_CYC >= SAMPLE_CYC) begin : g_bad_leb
            $error("blanking must end before the sample point");
        end
        if (SAMPLE_CYC >= MAX_ON_CYC) begin : g_bad_sample
            $error("sample point must lie inside the maximum on-time");
        end
    endgenerate

    logic [CW-1:0] on_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_cnt_q <= '0;
        end else if (!gate_in) begin
            on_cnt_q <= '0;
        end else if (on_cnt_q != CW'(CNT_MAX)) begin
            on_cnt_q <= on_cnt_q + 1'b1;
        end
    end

    always_comb begin
        info.blank  = gate_in && (on_cnt_q < CW'(LEB_CYC));
        info.strobe = gate_in && (on_cnt_q == CW'(SAMPLE_CYC));
    end

endmodule

// File: rtl/cs_thresh_gen.sv
module cs_thresh_gen
    import cs_short_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] line_code,
    output logic [THR_W-1:0]  thr_mv
);
    always_ff @(posedge clk) begin
        if (rst) thr_mv <= THR_W'(THR_LO_MV);
        else     thr_mv <= thr_from_line(line_code);
    end
endmodule

// File: rtl/cs_fault_seq.sv
module cs_fault_seq
    import cs_short_pkg::*;
#(
    parameter int FAULT_CNT = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic low,
    input  logic clr,
    output logic pulse
);
    localparam int CW = $clog2(FAULT_CNT + 1);

    logic [CW-1:0] run_q;
    arm_state_t    arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            arm_q <= ARM_READY;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (clr) begin
                run_q <= '0;
                arm_q <= ARM_READY;
            end else if (strobe) begin
                if (low) begin
                    if (run_q != CW'(FAULT_CNT)) run_q <= run_q + 1'b1;
                    if (run_q == CW'(FAULT_CNT - 1) && arm_q == ARM_READY) begin
                        pulse <= 1'b1;
                        arm_q <= ARM_SPENT;
                    end
                end else begin
                    run_q <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/cs_short_det.sv
module cs_short_det
    import cs_short_pkg::*;
#(
    parameter int LEB_CYC    = 28,
    parameter int SAMPLE_CYC = 455,
    parameter int FAULT_CNT  = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gate_in,
    input  logic [SENSE_W-1:0] sense_mv,
    input  logic [LINE_W-1:0]  line_code,
    input  logic               ilim_raw,
    input  logic               clr_req,
    output logic               fault_req,
    output logic               leb_blank,
    output logic               ilim_trip,
    output logic [THR_W-1:0]   thresh_mv
);
    on_info_t info;
    logic     sample_low;

    cs_on_timer #(.LEB_CYC(LEB_CYC), .SAMPLE_CYC(SAMPLE_CYC)) u_timer (
        .clk(clk), .rst(rst), .gate_in(gate_in), .info(info)
    );

    cs_thresh_gen u_thr (
        .clk(clk), .rst(rst), .line_code(line_code), .thr_mv(thresh_mv)
    );

    assign sample_low = (sense_mv < thresh_mv);

    cs_fault_seq #(.FAULT_CNT(FAULT_CNT)) u_seq (
        .clk(clk), .rst(rst), .strobe(info.strobe), .low(sample_low),
        .clr(clr_req), .pulse(fault_req)
    );

    assign leb_blank = info.blank;
    assign ilim_trip = ilim_raw & gate_in & ~info.blank;

endmodule

// File: rtl/cs_short_det_chk.sv
module cs_short_det_chk
    import cs_short_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             gate_in,
    input logic             clr_req,
    input logic             fault_req,
    input logic             leb_blank,
    input logic             ilim_trip,
    input logic [THR_W-1:0] thresh_mv
);
    logic spent_q;

    always_ff @(posedge clk) begin
        if (rst)            spent_q <= 1'b0;
        else if (clr_req)   spent_q <= 1'b0;
        else if (fault_req) spent_q <= 1'b1;
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        fault_req |=> !fault_req); // R6

    AST_NO_REPEAT_BEFORE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        fault_req |-> !spent_q); // R7

    AST_REQ_AFTER_ON_TIME: assert property (@(posedge clk) disable iff (rst)
        fault_req |-> $past(gate_in)); // R2

    AST_TRIP_OUTSIDE_BLANK: assert property (@(posedge clk) disable iff (rst)
        ilim_trip |-> (!leb_blank && gate_in)); // R8

    AST_BLANK_NEEDS_GATE: assert property (@(posedge clk) disable iff (rst)
        leb_blank |-> gate_in); // R9

    AST_THRESH_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        (thresh_mv >= THR_W'(THR_LO_MV)) && (thresh_mv <= THR_W'(THR_HI_MV))); // R1

endmodule

bind cs_short_det cs_short_det_chk u_chk (
    .clk(clk), .rst(rst), .gate_in(gate_in), .clr_req(clr_req),
    .fault_req(fault_req), .leb_blank(leb_blank), .ilim_trip(ilim_trip),
    .thresh_mv(thresh_mv)
);

// File: tb/cs_short_det_bench.sv
module cs_short_det_bench;
    localparam int CLK_PERIOD_NS = 10;
    localparam int LONG_ON  = 500;
    localparam int SHORT_ON = 300;
    localparam int OFF_CYC  = 100;
    localparam int WATCHDOG = 190000;
    localparam int NVEC     = 12;
    // {line code in V, expected threshold in mV}
    localparam int VEC [NVEC][2] = '{
        '{0, 50}, '{121, 50}, '{122, 50}, '{123, 50}, '{127, 51}, '{200, 65},
        '{244, 75}, '{300, 86}, '{365, 99}, '{366, 100}, '{367, 100}, '{1023, 100}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       gate_in = 1'b0;
    logic [7:0] sense_mv = 8'd200;
    logic [9:0] line_code = 10'd122;
    logic       ilim_raw = 1'b0;
    logic       clr_req = 1'b0;
    logic       fault_req, leb_blank, ilim_trip;
    logic [7:0] thresh_mv;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    int wide   = 0;
    bit prev_fault = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD_NS/2) clk = ~clk;

    cs_short_det u_cs_short_det (
        .clk(clk), .rst(rst), .gate_in(gate_in), .sense_mv(sense_mv),
        .line_code(line_code), .ilim_raw(ilim_raw), .clr_req(clr_req),
        .fault_req(fault_req), .leb_blank(leb_blank), .ilim_trip(ilim_trip),
        .thresh_mv(thresh_mv)
    );

    always @(negedge clk) begin
        if (fault_req) pulses++;
        if (fault_req && prev_fault) wide++;
        prev_fault = fault_req;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sw_cycle(input int on_cyc, input int mv);
        @(negedge clk);
        sense_mv = 8'(mv);
        gate_in = 1'b1;
        repeat (on_cyc) @(negedge clk);
        gate_in = 1'b0;
        repeat (OFF_CYC) @(negedge clk);
    endtask

    task automatic run(input int n, input int on_cyc, input int mv);
        for (int i = 0; i < n; i++) sw_cycle(on_cyc, mv);
    endtask

    task automatic do_clear();
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
    endtask

    task automatic set_line(input int v);
        @(negedge clk); line_code = 10'(v);
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int p0;
        repeat (4) @(negedge clk);
        chk(!fault_req && !leb_blank && !ilim_trip, "R10 outputs in reset", fault_req, 0);
        chk(thresh_mv == 8'd50, "R1 reset threshold", thresh_mv, 50);
        rst = 1'b0;
        @(negedge clk);
        chk(!fault_req && !leb_blank && !ilim_trip, "R10 outputs after reset", fault_req, 0);

        // R1 threshold table
        for (int k = 0; k < NVEC; k++) begin
            line_code = 10'(VEC[k][0]);
            @(negedge clk);
            chk(thresh_mv == 8'(VEC[k][1]), $sformatf("R1 line=%0d", VEC[k][0]),
                thresh_mv, VEC[k][1]);
        end

        // R8 / R9 blanking
        set_line(122);
        ilim_raw = 1'b1;
        @(negedge clk);
        chk(!ilim_trip, "R9 gate low", ilim_trip, 0);
        gate_in = 1'b1;
        #1;
        chk(leb_blank && !ilim_trip, "R8 blank at rise", ilim_trip, 0);
        repeat (27) @(negedge clk);
        chk(leb_blank && !ilim_trip, "R8 blank at 27 edges", leb_blank, 1);
        @(negedge clk);
        chk(!leb_blank && ilim_trip, "R9 trip after blanking", ilim_trip, 1);
        gate_in = 1'b0;
        #1;
        chk(!ilim_trip && !leb_blank, "R9 gate fall", ilim_trip, 0);
        ilim_raw = 1'b0;
        repeat (OFF_CYC) @(negedge clk);

        // R3 eleven consecutive lows
        p0 = pulses;
        run(10, LONG_ON, 49);
        chk(pulses == p0, "R3 ten lows", pulses - p0, 0);
        run(1, LONG_ON, 49);
        chk(pulses == p0 + 1, "R3 eleventh low", pulses - p0, 1);
        chk(wide == 0, "R6 pulse width", wide, 0);

        // R7 no repeat before clear
        run(11, LONG_ON, 49);
        chk(pulses == p0 + 1, "R7 no repeat", pulses - p0, 1);

        // R4 pass resets, R2 equality passes
        do_clear();
        p0 = pulses;
        run(10, LONG_ON, 49);
        run(1, LONG_ON, 50);
        run(10, LONG_ON, 49);
        chk(pulses == p0, "R4 R2 equal sample clears run", pulses - p0, 0);
        run(1, LONG_ON, 49);
        chk(pulses == p0 + 1, "R4 fresh run of eleven", pulses - p0, 1);

        // R7 clear zeroes run
        do_clear();
        p0 = pulses;
        run(10, LONG_ON, 49);
        do_clear();
        run(1, LONG_ON, 49);
        chk(pulses == p0, "R7 clear zeroes run", pulses - p0, 0);

        // R5 short cycles skipped
        do_clear();
        p0 = pulses;
        run(10, LONG_ON, 49);
        run(3, SHORT_ON, 0);
        chk(pulses == p0, "R5 shorts do not count", pulses - p0, 0);
        run(1, LONG_ON, 49);
        chk(pulses == p0 + 1, "R5 shorts do not reset", pulses - p0, 1);
        do_clear();
        p0 = pulses;
        run(5, LONG_ON, 49);
        run(6, SHORT_ON, 0);
        chk(pulses == p0, "R5 mixed five plus six shorts", pulses - p0, 0);

        // R2 high-line threshold
        set_line(366);
        do_clear();
        p0 = pulses;
        run(11, LONG_ON, 100);
        chk(pulses == p0, "R2 high line equal", pulses - p0, 0);
        run(11, LONG_ON, 99);
        chk(pulses == p0 + 1, "R2 high line below", pulses - p0, 1);
        chk(wide == 0, "R6 pulse width end", wide, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule